// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

This block is a compact processor built as a controller state machine that drives a separate datapath. The datapath holds a 16-bit program counter, a 16-bit instruction register, a sixteen-word register file with one write port and two read ports, and a single ALU. One memory port carries both instructions and data. It has an address, a read strobe, a write strobe and separate read and write data buses. The memory is outside the block. It answers reads combinationally and accepts a write on the clock edge at which the write strobe is high.

Every instruction takes three clock cycles. In the first cycle the instruction word is fetched and the program counter advances. The second cycle decodes the instruction. In the third cycle a single execute step runs, selected by the opcode. The instruction set has seven operations: load from a direct address, store to a direct address, store through a register pointer, load an 8-bit constant, add, subtract, and branch when a register is zero. Any other opcode does nothing and the core returns to the fetch cycle.

Top module: `mfc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core presents address 0 with the read strobe high and the write strobe low. The first instruction therefore comes from word 0.
- R2: Each instruction takes exactly three cycles. In the fetch cycle the word at the program counter is read and the counter increments by one, so the next fetch comes three cycles later at the following address. The read strobe is low in the decode cycle.
- R3: The instruction word layout is: opcode in bits 15:12, first register index (rn) in bits 11:8, second register index (rm) in bits 7:4, and an 8-bit field (address, constant or branch target) in bits 7:0. Opcode 0000 loads rn with the full 16-bit memory word at the 8-bit address.
- R4: Opcode 0001 writes register rn to memory at the 8-bit address.
- R5: Opcode 0010 writes register rm to memory at the address held in register rn. When rn equals rm, the register's own value is written at that value.
- R6: Opcode 0011 loads rn with the 8-bit field, zero-extended to 16 bits.
- R7: Opcode 0100 sets rn to rn + rm and opcode 0101 sets rn to rn - rm. Both wrap modulo 2^16.
- R8: Opcode 0110 loads the program counter with the zero-extended 8-bit field when register rn is zero. Otherwise execution continues at the next word.
- R9: Opcodes 0111 through 1111 change no register and write no memory.
- R10: The read and write strobes are never high together. A write occurs only in the execute cycle of opcodes 0001 and 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 16 | Word address for the memory |
| memRdEn | output | 1 | Read strobe |
| memWrEn | output | 1 | Write strobe, the write takes effect at the next rising edge |
| memWrData | output | 16 | Data to be written |
| memRdData | input | 16 | Read data, valid in the same cycle as the address |

## Verification
Two sets of events coincide in one cycle. In fetch, the memory read, the instruction-register load and the counter increment all happen on the same edge. In a taken branch, the target replaces a counter value that has already been incremented. The bench starts each small program from reset and judges fetch timing by the address seen three cycles later. It judges branches by which of two alternative stores lands in memory. A second coincidence is a pointer store with rn equal to rm, where one register read supplies both the address and the data. The bench runs that case and checks the word at the register's own value. All results are read back through stores into the bench's memory model, so every check is made at the ports.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int DataW = 16;
  localparam int AddrW = 16;
  localparam int RegN  = 16;
  localparam int RegAW = $clog2(RegN);
  localparam int OpW   = 4;
  localparam int FldW  = 8;

  localparam logic [OpW-1:0] OP_LOAD_DIR  = 4'h0;
  localparam logic [OpW-1:0] OP_STORE_DIR = 4'h1;
  localparam logic [OpW-1:0] OP_STORE_PTR = 4'h2;
  localparam logic [OpW-1:0] OP_LOAD_K    = 4'h3;
  localparam logic [OpW-1:0] OP_ADD       = 4'h4;
  localparam logic [OpW-1:0] OP_SUB       = 4'h5;
  localparam logic [OpW-1:0] OP_BR_ZERO   = 4'h6;

  typedef enum logic [1:0] {ST_FETCH, ST_DECODE, ST_EXEC} state_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_CONST} wbSel_e;
  typedef enum logic [1:0] {MA_PC, MA_FIELD, MA_REG} maSel_e;
  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB} aluOp_e;

  typedef struct packed {
    logic             irLd;
    logic             pcInc;
    logic             pcLd;
    logic             rfWe;
    logic [RegAW-1:0] rfWa;
    logic             rfR1e;
    logic [RegAW-1:0] rfR1a;
    logic             rfR2e;
    logic [RegAW-1:0] rfR2a;
    wbSel_e           wbSel;
    maSel_e           maSel;
    aluOp_e           aluOp;
    logic             memRe;
    logic             memWe;
  } ctrl_t;
endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OpW-1:0]   opcode,
  input  logic [RegAW-1:0] fldRn,
  input  logic [RegAW-1:0] fldRm,
  input  logic             aluZero,
  output ctrl_t            ctl
);
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    ctl.wbSel = WB_ALU;
    ctl.maSel = MA_PC;
    ctl.aluOp = ALU_PASS;
    stateNext = state;
    unique case (state)
      ST_FETCH: begin
        ctl.maSel = MA_PC;
        ctl.memRe = 1'b1;
        ctl.irLd  = 1'b1;
        ctl.pcInc = 1'b1;
        stateNext = ST_DECODE;
      end
      ST_DECODE: stateNext = ST_EXEC;
      ST_EXEC: begin
        stateNext = ST_FETCH;
        unique case (opcode)
          OP_LOAD_DIR: begin
            ctl.maSel = MA_FIELD;
            ctl.memRe = 1'b1;
            ctl.rfWe  = 1'b1;
            ctl.rfWa  = fldRn;
            ctl.wbSel = WB_MEM;
          end
          OP_STORE_DIR: begin
            ctl.maSel = MA_FIELD;
            ctl.rfR2e = 1'b1;
            ctl.rfR2a = fldRn;
            ctl.memWe = 1'b1;
          end
          OP_STORE_PTR: begin
            ctl.maSel = MA_REG;
            ctl.rfR1e = 1'b1;
            ctl.rfR1a = fldRn;
            ctl.rfR2e = 1'b1;
            ctl.rfR2a = fldRm;
            ctl.memWe = 1'b1;
          end
          OP_LOAD_K: begin
            ctl.rfWe  = 1'b1;
            ctl.rfWa  = fldRn;
            ctl.wbSel = WB_CONST;
          end
          OP_ADD, OP_SUB: begin
            ctl.rfR1e = 1'b1;
            ctl.rfR1a = fldRn;
            ctl.rfR2e = 1'b1;
            ctl.rfR2a = fldRm;
            ctl.aluOp = (opcode == OP_ADD) ? ALU_ADD : ALU_SUB;
            ctl.rfWe  = 1'b1;
            ctl.rfWa  = fldRn;
            ctl.wbSel = WB_ALU;
          end
          OP_BR_ZERO: begin
            ctl.rfR1e = 1'b1;
            ctl.rfR1a = fldRn;
            ctl.aluOp = ALU_PASS;
            ctl.pcLd  = aluZero;
          end
          default: ;
        endcase
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  // R2: execute always hands back to fetch
  a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_EXEC |=> state == ST_FETCH);
  // R2: decode always follows fetch
  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH |=> state == ST_DECODE);
endmodule

// File: rtl/mfc_dpath.sv
module mfc_dpath
  import mfc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [DataW-1:0] memRdData,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWrData,
  output logic [OpW-1:0]   opcode,
  output logic [RegAW-1:0] fldRn,
  output logic [RegAW-1:0] fldRm,
  output logic             aluZero
);
  logic [AddrW-1:0] pc;
  logic [DataW-1:0] ir;
  logic [DataW-1:0] rf [RegN];
  logic [DataW-1:0] rd1, rd2, aluY, wbData;
  logic [FldW-1:0]  fld8;

  assign opcode = ir[DataW-1 -: OpW];
  assign fldRn  = ir[DataW-OpW-1 -: RegAW];
  assign fldRm  = ir[FldW-1 -: RegAW];
  assign fld8   = ir[FldW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (ctl.irLd) ir <= memRdData;
      if (ctl.pcLd)       pc <= AddrW'(fld8);
      else if (ctl.pcInc) pc <= pc + AddrW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RegN; i++) rf[i] <= '0;
    end else if (ctl.rfWe) begin
      rf[ctl.rfWa] <= wbData;
    end
  end

  assign rd1 = ctl.rfR1e ? rf[ctl.rfR1a] : '0;
  assign rd2 = ctl.rfR2e ? rf[ctl.rfR2a] : '0;

  always_comb begin
    unique case (ctl.aluOp)
      ALU_ADD: aluY = rd1 + rd2;
      ALU_SUB: aluY = rd1 - rd2;
      default: aluY = rd1;
    endcase
  end
  assign aluZero = (aluY == '0);

  always_comb begin
    unique case (ctl.wbSel)
      WB_MEM:   wbData = memRdData;
      WB_CONST: wbData = DataW'(fld8);
      default:  wbData = aluY;
    endcase
  end

  always_comb begin
    unique case (ctl.maSel)
      MA_FIELD: memAddr = AddrW'(fld8);
      MA_REG:   memAddr = AddrW'(rd1);
      default:  memAddr = pc;
    endcase
  end
  assign memWrData = rd2;

  // R2: a fetch advances the counter by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irLd |=> pc == $past(pc) + AddrW'(1));
  // R8: a taken branch lands on the zero-extended field
  a_r8_branch_target: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcLd |=> pc == AddrW'($past(fld8)));
  // R9: spare opcodes never write state
  a_r9_spare_silent: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rfWe || ctl.memWe) |-> opcode <= OP_SUB);
  // R10: stores only come from the two store opcodes
  a_r10_store_opcode: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memWe |-> (opcode == OP_STORE_DIR || opcode == OP_STORE_PTR));
endmodule

// File: rtl/mfc_core.sv
module mfc_core
  import mfc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  output logic [AddrW-1:0] memAddr,
  output logic             memRdEn,
  output logic             memWrEn,
  output logic [DataW-1:0] memWrData,
  input  logic [DataW-1:0] memRdData
);
  ctrl_t            ctl;
  logic [OpW-1:0]   opcode;
  logic [RegAW-1:0] fldRn, fldRm;
  logic             aluZero;

  mfc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .fldRn(fldRn),
    .fldRm(fldRm), .aluZero(aluZero), .ctl(ctl)
  );

  mfc_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .opcode(opcode),
    .fldRn(fldRn), .fldRm(fldRm), .aluZero(aluZero)
  );

  assign memRdEn = ctl.memRe;
  assign memWrEn = ctl.memWe;

  // R10: read and write strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));
endmodule

// File: tb/mfc_core_tb.sv
module mfc_core_tb_top;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr, memWrData, memRdData;
  logic        memRdEn, memWrEn;
  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  int bothStrobes = 0;

  always #(ClkPeriod/2) clk = ~clk;

  mfc_core dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData)
  );

  assign memRdData = mem[memAddr[7:0]];
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr[7:0]] <= memWrData;
    if (rstN && memWrEn && memRdEn) bothStrobes++;
  end

  // vector: {opcode, a, b, expected}; program computes R1 op R2 and stores R1 at 0xF0
  localparam logic [35:0] Vecs [10] = '{
    {4'h4, 8'h05, 8'h07, 16'h000C},
    {4'h4, 8'hFF, 8'hFF, 16'h01FE},
    {4'h4, 8'h00, 8'h00, 16'h0000},
    {4'h5, 8'h09, 8'h04, 16'h0005},
    {4'h5, 8'h03, 8'h05, 16'hFFFE},
    {4'h5, 8'h80, 8'h80, 16'h0000},
    {4'h7, 8'h21, 8'h33, 16'h0021},
    {4'hA, 8'h10, 8'h01, 16'h0010},
    {4'hC, 8'h5C, 8'h02, 16'h005C},
    {4'hF, 8'h44, 8'h12, 16'h0044}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startFresh();
    rstN = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic release_run(input int n);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 and R2: reset state and fetch cadence
    startFresh();
    mem[0] = 16'h3100;
    mem[1] = 16'h3200;
    repeat (2) @(negedge clk);
    check("R1 addr in reset", memAddr, 16'h0000);
    check("R1 wr low in reset", {15'b0, memWrEn}, 16'h0000);
    rstN = 1'b1;
    check("R1 first fetch addr", memAddr, 16'h0000);
    check("R1 first fetch rd", {15'b0, memRdEn}, 16'h0001);
    @(negedge clk);
    check("R2 decode rd low", {15'b0, memRdEn}, 16'h0000);
    repeat (2) @(negedge clk);
    check("R2 second fetch addr", memAddr, 16'h0001);
    check("R2 second fetch rd", {15'b0, memRdEn}, 16'h0001);

    // R7 and R9: vector table
    foreach (Vecs[k]) begin
      startFresh();
      mem[0] = {4'h3, 4'h1, Vecs[k][31:24]};
      mem[1] = {4'h3, 4'h2, Vecs[k][23:16]};
      mem[2] = {Vecs[k][35:32], 4'h1, 4'h2, 4'h0};
      mem[3] = 16'h11F0;
      mem[4] = 16'h3300;
      mem[5] = 16'h6305;
      release_run(30);
      check(Vecs[k][35:32] > 4'h5 ? "R9 spare opcode" : "R7 add/sub", mem[8'hF0], Vecs[k][15:0]);
    end

    // R3: direct load of a full word, R4 store
    startFresh();
    mem[8'h80] = 16'hA5C3;
    mem[0] = 16'h0580;
    mem[1] = 16'h15F2;
    mem[2] = 16'h3300;
    mem[3] = 16'h6303;
    release_run(20);
    check("R3 direct load", mem[8'hF2], 16'hA5C3);

    // R5: pointer store, including rn == rm
    startFresh();
    mem[0] = 16'h34F3;
    mem[1] = 16'h365A;
    mem[2] = 16'h2460;
    mem[3] = 16'h37F4;
    mem[4] = 16'h2770;
    mem[5] = 16'h3300;
    mem[6] = 16'h6306;
    release_run(30);
    check("R5 pointer store", mem[8'hF3], 16'h005A);
    check("R5 pointer store rn==rm", mem[8'hF4], 16'h00F4);

    // R6: constant zero-extended
    startFresh();
    mem[0] = 16'h39FE;
    mem[1] = 16'h19FA;
    mem[2] = 16'h3300;
    mem[3] = 16'h6303;
    release_run(20);
    check("R6 constant zero-extend", mem[8'hFA], 16'h00FE);

    // R8: branch not taken
    startFresh();
    mem[0] = 16'h3101;
    mem[1] = 16'h6105;
    mem[2] = 16'h3811;
    mem[3] = 16'h18F5;
    mem[4] = 16'h3300;
    mem[5] = 16'h6305;
    release_run(30);
    check("R8 not taken", mem[8'hF5], 16'h0011);

    // R8: branch taken skips a store
    startFresh();
    mem[0] = 16'h3200;
    mem[1] = 16'h6204;
    mem[2] = 16'h38EE;
    mem[3] = 16'h18F6;
    mem[4] = 16'h3822;
    mem[5] = 16'h18F7;
    mem[6] = 16'h6206;
    release_run(30);
    check("R8 taken skip", mem[8'hF6], 16'h0000);
    check("R8 taken target", mem[8'hF7], 16'h0022);

    // R7: wrap both directions
    startFresh();
    mem[8'hF9] = 16'hDEAD;
    mem[0] = 16'h3100;
    mem[1] = 16'h3201;
    mem[2] = 16'h5120;
    mem[3] = 16'h11F8;
    mem[4] = 16'h4120;
    mem[5] = 16'h11F9;
    mem[6] = 16'h3300;
    mem[7] = 16'h6307;
    release_run(40);
    check("R7 sub wrap", mem[8'hF8], 16'hFFFF);
    check("R7 add wrap", mem[8'hF9], 16'h0000);

    // R8 and R7: countdown sum 10..1
    startFresh();
    mem[0] = 16'h3000;
    mem[1] = 16'h310A;
    mem[2] = 16'h3201;
    mem[3] = 16'h3300;
    mem[4] = 16'h6108;
    mem[5] = 16'h4010;
    mem[6] = 16'h5120;
    mem[7] = 16'h6304;
    mem[8] = 16'h10F1;
    mem[9] = 16'h6309;
    release_run(400);
    check("R8 countdown sum", mem[8'hF1], 16'd55);

    // R10: strobes never coincided over all runs
    check("R10 strobe overlap", 16'(bothStrobes), 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule